// File: doc/BRIEF.md
# NOR Flash Erase Command Sequencer

This block sits on the host side of an asynchronous NOR flash bus and turns a single request into the write cycles that start an erase, or that suspend or resume an embedded operation. The user gives an operation code and a target word address. The block then drives the flash address, the 16-bit write data with its output enable, chip enable and write enable. It holds `busy` high until the last write-enable rising edge has been driven and its high time has run out, and then pulses `done` for one clock.

An erase always takes six bus cycles. The first five carry fixed unlock address/data pairs, which are parameters. In the sixth cycle the low data byte (0x10, 0x20 or 0x30) sets whether the whole chip, one plane or one sector is erased. Suspend and resume each take a single bus cycle. One suspend code covers both an erase in progress and a program in progress, and one resume code covers both.

Every write is controlled by write enable. Address and data are set up one clock before write enable falls and stay put until the high time after its rising edge has elapsed. Chip enable stays low across all cycles of a sequence. Parameters set the low and high widths of write enable in clocks.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset the bus is idle: `flash_ce_n`=1, `flash_we_n`=1, `flash_dq_oe`=0, `busy`=0, `done`=0.
- R2: Operation codes 0 (chip), 1 (plane) and 2 (sector) produce exactly six write cycles. The first five cycles are, in order: (0x555,0x00AA), (0x2AA,0x0055), (0x555,0x0080), (0x555,0x00AA), (0x2AA,0x0055).
- R3: The data of the sixth erase cycle is 0x0010 for code 0, 0x0020 for code 1 and 0x0030 for code 2. The upper byte is zero.
- R4: The address of the sixth erase cycle is 0x555 for chip erase and the request's target address for plane and sector erase.
- R5: Code 3 (suspend) produces one write cycle of data 0x00B0, and code 4 (resume) produces one write cycle of data 0x0030. Both are written to the target address, and the same codes are used whether an erase or a program is in progress.
- R6: Write enable stays low for exactly T_WP clocks in each cycle. Address and data are already valid one clock before it falls and do not change while it is low.
- R7: Between the write-enable pulses of one sequence, write enable is high for T_WPH+1 clocks. Chip enable stays low from the first setup clock to the end of the last high time.
- R8: `done` is a single-clock pulse T_WPH+1 clocks after the last write-enable rising edge is sampled. It is high in the first clock in which `busy` is low.
- R9: A request made while `busy` is high has no effect. A request with code 5, 6 or 7 is ignored and the bus stays idle.
- R10: `flash_dq_oe` is high exactly while `flash_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 3 | Operation: 0 chip, 1 plane, 2 sector, 3 suspend, 4 resume |
| req_addr | input | AW | Target word address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock pulse at sequence end |
| flash_addr | output | AW | Flash address bus |
| flash_dq_o | output | DW | Flash write data |
| flash_dq_oe | output | 1 | Data driver enable (0 = tri-stated) |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |

## Verification
The embedded assertions assume that `req_op`, `req_addr` and `req_valid` are known at every clock edge, and that the target address does not matter once a request has been taken. The bench changes inputs only on the falling clock edge and holds each request for exactly one clock. It draws codes 0 to 4 and full-width addresses at random, and adds directed cases for out-of-range codes and for requests made while `busy` is high.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

   typedef enum logic [2:0] {
      OP_CHIP    = 3'd0,
      OP_PLANE   = 3'd1,
      OP_SECTOR  = 3'd2,
      OP_SUSPEND = 3'd3,
      OP_RESUME  = 3'd4
   } erase_op_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_LOW,
      PH_HIGH
   } bus_phase_e;

   localparam int ERASE_STEPS = 6;
   localparam int STEP_W      = 3;

   function automatic logic op_known(input logic [2:0] op);
      return op <= 3'd4;
   endfunction

   function automatic logic op_is_erase(input logic [2:0] op);
      return op <= 3'd2;
   endfunction

endpackage

// File: rtl/nor_bus_phase.sv
module nor_bus_phase
   import nor_erase_pkg::*;
#(
   parameter int T_WP  = 3,
   parameter int T_WPH = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       last,
   output bus_phase_e phase,
   output logic       step
);
   localparam int MAXT = (T_WP > T_WPH) ? T_WP : T_WPH;
   localparam int CW   = $clog2(MAXT + 1);

   logic [CW-1:0] cnt_q;

   initial begin
      assert (T_WP >= 1) else $error("T_WP must be at least 1");
      assert (T_WPH >= 1) else $error("T_WPH must be at least 1");
   end

   assign step = (phase == PH_HIGH) && (cnt_q == CW'(T_WPH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) phase <= PH_SETUP;
               cnt_q <= '0;
            end
            PH_SETUP: begin
               phase <= PH_LOW;
               cnt_q <= '0;
            end
            PH_LOW: begin
               if (cnt_q == CW'(T_WP - 1)) begin
                  phase <= PH_HIGH;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               if (step) begin
                  phase <= last ? PH_IDLE : PH_SETUP;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   // R6
   low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOW) |-> (cnt_q < CW'(T_WP)));

   // R7
   high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HIGH) |-> (cnt_q < CW'(T_WPH)));

endmodule

// File: rtl/nor_cmd_rom.sv
module nor_cmd_rom
   import nor_erase_pkg::*;
#(
   parameter int            AW        = 22,
   parameter int            DW        = 16,
   parameter logic [AW-1:0] KEY_ADDR1 = AW'('h555),
   parameter logic [AW-1:0] KEY_ADDR2 = AW'('h2AA),
   parameter logic [7:0]    KEY_DATA1 = 8'hAA,
   parameter logic [7:0]    KEY_DATA2 = 8'h55,
   parameter logic [7:0]    ERASE_ARM = 8'h80,
   parameter logic [7:0]    SUSP_CMD  = 8'hB0,
   parameter logic [7:0]    RESM_CMD  = 8'h30
) (
   input  logic [2:0]        op,
   input  logic [STEP_W-1:0] idx,
   input  logic [AW-1:0]     tgt,
   output logic [AW-1:0]     addr,
   output logic [DW-1:0]     data
);
   logic [7:0] code;

   always_comb begin
      addr = tgt;
      code = 8'h00;
      if (op_is_erase(op)) begin
         case (idx)
            3'd0, 3'd3: begin addr = KEY_ADDR1; code = KEY_DATA1; end
            3'd1, 3'd4: begin addr = KEY_ADDR2; code = KEY_DATA2; end
            3'd2:       begin addr = KEY_ADDR1; code = ERASE_ARM; end
            default: begin
               addr = (op == OP_CHIP) ? KEY_ADDR1 : tgt;
               code = {2'b00, op[1:0] + 2'd1, 4'h0};
            end
         endcase
      end else if (op == OP_SUSPEND) begin
         code = SUSP_CMD;
      end else begin
         code = RESM_CMD;
      end
   end

   generate
      if (DW == 8) begin : g_narrow
         assign data = code;
      end else begin : g_wide
         assign data = {{(DW - 8){1'b0}}, code};
      end
   endgenerate

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
   import nor_erase_pkg::*;
#(
   parameter int AW    = 22,
   parameter int DW    = 16,
   parameter int T_WP  = 3,
   parameter int T_WPH = 2,
   parameter logic [7:0] SUSP_CMD = 8'hB0,
   parameter logic [7:0] RESM_CMD = 8'h30
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [2:0]    req_op,
   input  logic [AW-1:0] req_addr,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] flash_addr,
   output logic [DW-1:0] flash_dq_o,
   output logic          flash_dq_oe,
   output logic          flash_ce_n,
   output logic          flash_we_n
);
   initial begin
      assert (AW >= 12) else $error("AW too small for unlock addresses");
      assert (DW >= 8) else $error("DW must hold a command byte");
   end

   bus_phase_e          phase;
   logic                step, start, last;
   logic [2:0]          op_q;
   logic [AW-1:0]       tgt_q;
   logic [STEP_W-1:0]   idx_q;
   logic                done_q;

   assign start = req_valid && (phase == PH_IDLE) && op_known(req_op);
   assign last  = op_is_erase(op_q) ? (idx_q == STEP_W'(ERASE_STEPS - 1)) : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= 3'd0;
         tgt_q  <= '0;
         idx_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= step && last;
         if (start) begin
            op_q  <= req_op;
            tgt_q <= req_addr;
            idx_q <= '0;
         end else if (step && !last) begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   nor_bus_phase #(.T_WP(T_WP), .T_WPH(T_WPH)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .last  (last),
      .phase (phase),
      .step  (step)
   );

   logic [AW-1:0] rom_addr;
   logic [DW-1:0] rom_data;

   nor_cmd_rom #(.AW(AW), .DW(DW), .SUSP_CMD(SUSP_CMD), .RESM_CMD(RESM_CMD)) u_rom (
      .op   (op_q),
      .idx  (idx_q),
      .tgt  (tgt_q),
      .addr (rom_addr),
      .data (rom_data)
   );

   assign busy        = (phase != PH_IDLE);
   assign done        = done_q;
   assign flash_ce_n  = (phase == PH_IDLE);
   assign flash_we_n  = (phase != PH_LOW);
   assign flash_dq_oe = busy;
   assign flash_addr  = busy ? rom_addr : '0;
   assign flash_dq_o  = busy ? rom_data : '0;

   // R7
   ce_covers_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_we_n |-> !flash_ce_n);

   // R6
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_o)));

   // R6
   bus_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flash_we_n) |-> ($stable(flash_addr) && $stable(flash_dq_o) && $past(!flash_ce_n)));

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(op_q) && $stable(tgt_q)));

   // R10
   drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flash_dq_oe == !flash_ce_n);

endmodule

// File: tb/tb_nor_erase_seq.sv
`timescale 1ns/1ps
module tb_nor_erase_seq;
   localparam int AW = 22, DW = 16, TWP = 3, TWPH = 2;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_op = 3'd0;
   logic [AW-1:0] req_addr = '0;
   logic          busy, done, flash_dq_oe, flash_ce_n, flash_we_n;
   logic [AW-1:0] flash_addr;
   logic [DW-1:0] flash_dq_o;

   always #2 clk = ~clk;

   nor_erase_seq #(.AW(AW), .DW(DW), .T_WP(TWP), .T_WPH(TWPH)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .busy(busy), .done(done), .flash_addr(flash_addr),
      .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe),
      .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n));

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_len(input logic [2:0] op);
      return (op <= 3'd2) ? 6 : 1;
   endfunction

   function automatic logic [AW-1:0] exp_addr(input logic [2:0] op, input logic [AW-1:0] t, input int i);
      if (op > 3'd2) return t;
      case (i)
         0, 2, 3: return AW'('h555);
         1, 4:    return AW'('h2AA);
         default: return (op == 3'd0) ? AW'('h555) : t;
      endcase
   endfunction

   function automatic logic [DW-1:0] exp_data(input logic [2:0] op, input int i);
      if (op == 3'd3) return 16'h00B0;
      if (op == 3'd4) return 16'h0030;
      case (i)
         0, 3:    return 16'h00AA;
         1, 4:    return 16'h0055;
         2:       return 16'h0080;
         default: return (op == 3'd0) ? 16'h0010 : (op == 3'd1) ? 16'h0020 : 16'h0030;
      endcase
   endfunction

   // bus monitor, sampled on the falling clock edge
   logic [AW-1:0] cap_addr [8];
   logic [DW-1:0] cap_data [8];
   int  ncap = 0, lo_cnt = 0, hi_cnt = 100;
   bit  prev_we = 1'b1;
   logic [AW-1:0] prev_addr = '0;
   logic [DW-1:0] prev_data = '0;

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(flash_dq_oe == !flash_ce_n, "R10 oe", flash_dq_oe, !flash_ce_n);
         if (!flash_we_n) begin
            chk(!flash_ce_n, "R7 ce low during we", flash_ce_n, 0);
            if (prev_we) begin
               chk(prev_addr == flash_addr && prev_data == flash_dq_o, "R6 setup", prev_addr, flash_addr);
               if (ncap > 0) chk(hi_cnt == TWPH + 1, "R7 gap", hi_cnt, TWPH + 1);
               if (ncap < 8) begin
                  cap_addr[ncap] = flash_addr;
                  cap_data[ncap] = flash_dq_o;
               end
               ncap++;
               lo_cnt = 1;
            end else begin
               lo_cnt++;
               chk(prev_addr == flash_addr && prev_data == flash_dq_o, "R6 hold", flash_addr, prev_addr);
            end
         end else begin
            if (!prev_we) begin
               chk(lo_cnt == TWP, "R6 low width", lo_cnt, TWP);
               hi_cnt = 0;
            end
            hi_cnt++;
            if (busy) chk(!flash_ce_n, "R7 ce held", flash_ce_n, 0);
            if (done) begin
               chk(hi_cnt == TWPH + 1, "R8 done timing", hi_cnt, TWPH + 1);
               chk(!busy, "R8 busy low at done", busy, 0);
            end
         end
         prev_we   = flash_we_n;
         prev_addr = flash_addr;
         prev_data = flash_dq_o;
      end
   end

   task automatic run_op(input logic [2:0] op, input logic [AW-1:0] t, input bit poke);
      int n;
      string rq;
      @(negedge clk);
      ncap = 0;
      req_valid = 1'b1; req_op = op; req_addr = t;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy, "R2 busy after request", busy, 1);
      if (poke) begin
         req_valid = 1'b1; req_op = 3'd3; req_addr = ~t;
         @(negedge clk);
         req_valid = 1'b0;
      end
      n = 0;
      while (!done && n < 200) begin @(negedge clk); n++; end
      chk(done, "R8 done seen", done, 1);
      @(negedge clk);
      chk(!done, "R8 done one clock", done, 0);
      chk(ncap == exp_len(op), poke ? "R9 request while busy" : "R2 cycle count", ncap, exp_len(op));
      for (int i = 0; i < exp_len(op) && i < ncap; i++) begin
         rq = (op > 3'd2) ? "R5" : (i == 5) ? "R3" : "R2";
         chk(cap_data[i] == exp_data(op, i), rq, cap_data[i], exp_data(op, i));
         rq = (op > 3'd2) ? "R5" : (i == 5) ? "R4" : "R2";
         chk(cap_addr[i] == exp_addr(op, t, i), rq, cap_addr[i], exp_addr(op, t, i));
      end
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(flash_ce_n && flash_we_n && !flash_dq_oe && !busy && !done, "R1 reset idle",
          {flash_ce_n, flash_we_n, flash_dq_oe, busy, done}, 5'b11000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(flash_ce_n && !busy, "R1 idle after reset", flash_ce_n, 1);

      run_op(3'd0, AW'('h3ABCDE), 1'b0);
      run_op(3'd1, AW'('h100000), 1'b0);
      run_op(3'd2, AW'('h008000), 1'b0);
      run_op(3'd3, AW'('h000000), 1'b0);
      run_op(3'd4, AW'('h3FFFFF), 1'b0);
      run_op(3'd2, AW'('h012345), 1'b1);   // R9 request while busy

      // R9 codes 5..7 ignored
      for (int c = 5; c < 8; c++) begin
         @(negedge clk);
         ncap = 0;
         req_valid = 1'b1; req_op = 3'(c); req_addr = AW'('h1234);
         @(negedge clk);
         req_valid = 1'b0;
         repeat (10) @(negedge clk);
         chk(!busy && flash_ce_n && ncap == 0, "R9 bad code ignored", ncap, 0);
      end

      for (int k = 0; k < 40; k++) begin
         logic [2:0] op;
         op = 3'($urandom_range(4, 0));
         run_op(op, AW'($urandom), ($urandom_range(3, 0) == 0));
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule